// File: doc/BRIEF.md
# LIFO Register Stack with Pointer-Wrap Flags

A last-in, first-out store of 64 words held in flip-flops and addressed by a 6-bit top-of-stack pointer. A push moves the pointer up by one and then writes the incoming word at the new pointer position. A pop sends the word at the pointer to a registered output and then moves the pointer down by one. The first word pushed after reset therefore lands at address 1 and the 64th lands at address 0, so every location holds data.

Full and empty are two separate flag registers rather than a decode of an occupancy count. They change only on an accepted operation whose new pointer value is zero, and each opposite flag is cleared by every accepted operation. A push while full, a pop while empty, or a push and a pop in the same cycle is rejected. A rejected request leaves the pointer, the flags, the storage and the output word untouched and raises a one-cycle error pulse.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `err_o` is 0 and `rdata_o` is 0.
- R2: An accepted push advances the pointer before writing, so the most recently pushed word is the first one popped and a push followed by a pop returns the same word.
- R3: `full_o` rises on the accepted push that brings the pointer back to 0, which is the 64th push from empty. Every accepted push clears `empty_o`.
- R4: The word popped by an accepted pop appears on `rdata_o` in the cycle after the pop strobe and holds its value until the next accepted pop.
- R5: `empty_o` rises on the accepted pop that brings the pointer to 0. Every accepted pop clears `full_o`.
- R6: A push while `full_o` is 1 raises `err_o` in the next cycle and changes neither flags, stored words nor the pointer.
- R7: A pop while `empty_o` is 1 raises `err_o` in the next cycle and leaves `rdata_o`, the flags and the pointer unchanged.
- R8: Push and pop asserted in the same cycle are rejected as an error whatever the fill level, with no change of state.
- R9: `err_o` is a single-cycle pulse: it is 0 in the cycle after any accepted operation or idle cycle.
- R10: All 64 locations, including address 0, hold data: 64 pushes from empty are followed by 64 pops that return the words in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| wdata_i | input | DATA_W (8) | Word to push |
| rdata_o | output | DATA_W (8) | Last popped word, registered |
| full_o | output | 1 | Full flag register |
| empty_o | output | 1 | Empty flag register |
| err_o | output | 1 | One-cycle pulse on a rejected request |

## Verification
The bench builds the block with its default parameters, 8-bit words and a 6-bit pointer, so the full 64-entry depth and the wrap of the pointer through zero are reached in a few hundred cycles. At that depth the directed fill and drain covers address 0 as a data location, and overflow, underflow and colliding requests are reached at both ends of the stack. Random traffic with push-heavy and pop-heavy phases then crosses the full and empty boundaries many times against a queue model.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // Decoded request class for one cycle
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } lrs_op_e;

endpackage

// File: rtl/lrs_opdec.sv
module lrs_opdec
  import lrs_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output lrs_op_e op_o
);

  logic collide;
  logic overflow;
  logic underflow;

  assign collide   = push_i && pop_i;
  assign overflow  = push_i && !pop_i && full_i;
  assign underflow = pop_i && !push_i && empty_i;

  always_comb begin
    if (collide || overflow || underflow) op_o = OP_REJECT;
    else if (push_i)                      op_o = OP_PUSH;
    else if (pop_i)                       op_o = OP_POP;
    else                                  op_o = OP_IDLE;
  end

endmodule

// File: rtl/lrs_ptrctl.sv
module lrs_ptrctl
  import lrs_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lrs_op_e          op_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  function automatic logic at_base(input logic [PTR_W-1:0] p);
    return p == '0;
  endfunction

  logic [PTR_W-1:0] sp_q, sp_d;
  logic             full_q, full_d;
  logic             empty_q, empty_d;
  logic             err_q;

  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    unique case (op_i)
      OP_PUSH: begin
        sp_d    = ptr_up(sp_q);
        empty_d = 1'b0;
        if (at_base(sp_d)) full_d = 1'b1;
      end
      OP_POP: begin
        sp_d   = ptr_down(sp_q);
        full_d = 1'b0;
        if (at_base(sp_d)) empty_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= (op_i == OP_REJECT);
    end
  end

  assign sp_o      = sp_q;
  assign wr_addr_o = ptr_up(sp_q);
  assign rd_addr_o = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

endmodule

// File: rtl/lrs_store.sv
module lrs_store #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  for (genvar r = 0; r < DEPTH; r++) begin : g_cell
    logic hit;
    assign hit = we_i && (waddr_i == PTR_W'(r));
    always_ff @(posedge clk_i) begin
      if (hit) cell_q[r] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= cell_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import lrs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);

  lrs_op_e          op;
  logic             push_ok;
  logic             pop_ok;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] wr_addr;
  logic [PTR_W-1:0] rd_addr;

  lrs_opdec u_opdec (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full_o),
    .empty_i (empty_o),
    .op_o    (op)
  );

  assign push_ok = (op == OP_PUSH);
  assign pop_ok  = (op == OP_POP);

  lrs_ptrctl #(.PTR_W(PTR_W)) u_ptrctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .sp_o      (sp_q),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  lrs_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push_ok),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .re_i    (pop_ok),
    .raddr_i (rd_addr),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o,
  input logic [PTR_W-1:0]  sp,
  input logic              push_ok,
  input logic              pop_ok
);

  assert_push_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> sp == $past(sp) + PTR_W'(1));

  assert_push_clears_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> !empty_o);

  assert_full_at_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> sp == '0);

  assert_pop_clears_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |=> !full_o && sp == $past(sp) - PTR_W'(1));

  assert_empty_at_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> sp == '0);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp));

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && $stable(sp) && $stable(rdata_o));

  assert_collide_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> err_o && $stable(sp) && $stable(full_o) && $stable(empty_o));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok || pop_ok || (!push_i && !pop_i)) |=> !err_o);

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_ok |=> $stable(rdata_o));

endmodule

bind lifo_regstack lrs_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .rdata_o (rdata_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o),
  .sp      (sp_q),
  .push_ok (push_ok),
  .pop_ok  (pop_ok)
);

// File: tb/lifo_regstack_tb.sv
`timescale 1ns/1ps
module lifo_regstack_tb;

  localparam int DW    = 8;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          full_o, empty_o, err_o;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] mdl[$];
  logic [DW-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  lifo_regstack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .full_o(full_o),
    .empty_o(empty_o), .err_o(err_o)
  );

  function automatic bit rejected(input bit p, input bit q, input int fill);
    return (p && q) || (p && fill == DEPTH) || (q && fill == 0);
  endfunction

  function automatic logic [DW-1:0] fill_word(input int i);
    return DW'(i * 7 + 3);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input bit p, input bit q, input logic [DW-1:0] d);
    bit e;
    string etag;
    e = rejected(p, q, mdl.size());
    if (p && q)      etag = "R8";
    else if (e && p) etag = "R6";
    else if (e && q) etag = "R7";
    else             etag = "R9";
    push_i = p; pop_i = q; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    if (!e && p) mdl.push_back(d);
    if (!e && q) exp_rd = mdl.pop_back();
    chk(etag, "err_o", 32'(err_o), 32'(e));
    chk("R3", "full_o", 32'(full_o), 32'(mdl.size() == DEPTH));
    chk("R5", "empty_o", 32'(empty_o), 32'(mdl.size() == 0));
    chk("R4", "rdata_o", 32'(rdata_o), 32'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty_o", 32'(empty_o), 32'd1);
    chk("R1", "full_o", 32'(full_o), 32'd0);
    chk("R1", "err_o", 32'(err_o), 32'd0);
    chk("R1", "rdata_o", 32'(rdata_o), 32'd0);

    // R7 pop on empty, R8 collision on empty, then idle clears err (R9)
    do_op(1'b0, 1'b1, '0);
    do_op(1'b1, 1'b1, 8'h55);
    do_op(1'b0, 1'b0, '0);
    chk("R9", "err after idle", 32'(err_o), 32'd0);

    // R2 push then pop returns newest first
    do_op(1'b1, 1'b0, 8'hA1);
    do_op(1'b1, 1'b0, 8'hB2);
    do_op(1'b0, 1'b1, '0);
    chk("R2", "newest first", 32'(rdata_o), 32'hB2);
    do_op(1'b0, 1'b0, '0);
    chk("R4", "rdata held", 32'(rdata_o), 32'hB2);
    do_op(1'b0, 1'b1, '0);
    chk("R2", "older second", 32'(rdata_o), 32'hA1);
    chk("R5", "empty after drain", 32'(empty_o), 32'd1);

    // R10 fill all 64 locations
    for (int i = 0; i < DEPTH; i++) begin
      do_op(1'b1, 1'b0, fill_word(i));
      if (i == DEPTH - 2) chk("R3", "not full at 63", 32'(full_o), 32'd0);
    end
    chk("R3", "full after 64", 32'(full_o), 32'd1);
    // R6 overflow and R8 collision on full
    do_op(1'b1, 1'b0, 8'hEE);
    chk("R6", "full kept", 32'(full_o), 32'd1);
    do_op(1'b1, 1'b1, 8'hDD);
    for (int k = 0; k < DEPTH; k++) begin
      do_op(1'b0, 1'b1, '0);
      chk("R10", "drain order", 32'(rdata_o), 32'(fill_word(DEPTH - 1 - k)));
    end
    chk("R5", "empty after 64 pops", 32'(empty_o), 32'd1);
    do_op(1'b0, 1'b1, '0);
    chk("R7", "rdata kept", 32'(rdata_o), 32'(fill_word(0)));

    // random traffic: push-heavy then pop-heavy phases
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 700; n++) begin
        int r;
        bit p, q;
        r = int'($urandom % 100);
        if (ph % 2 == 0) begin p = (r < 70); q = (r >= 64 && r < 90); end
        else             begin p = (r < 30); q = (r >= 24 && r < 92); end
        do_op(p, q, DW'($urandom));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule